// File: doc/BRIEF.md
# Burst write data mask generator

This block turns one write request into the sequence of per-beat byte-lane masks for a fixed-length SDRAM write burst. The memory always receives a complete burst of four or eight beats. Only the beat that carries the requested doubleword has any lanes unmasked. Every other beat in the burst is fully masked, so the devices ignore it.

The mask bus has nine lanes: eight data byte lanes and one lane for the ECC check byte. When ECC is off, a partial doubleword write is handled by masking the bytes that are not enabled. When ECC is on, a partial write cannot be masked, because the check byte covers the whole doubleword. In that case the block emits no beats and raises a one-cycle read-modify-write request for a separate datapath to service.

The burst is issued critical-word-first. The beat column that the address offset selects comes first, and later beats wrap around the burst. A new request is taken only when no burst is running, or in the cycle that shows the last beat of the current burst, so bursts can follow each other without a gap.

Top module: `burst_wmask_gen`

## Requirements
- R1: After reset, `beat_valid`, `beat_last` and `rmw_req` are 0 and `req_ready` is 1.
- R2: A request is accepted when `req_valid` and `req_ready` are both 1 at a clock edge. If it does not need read-modify-write, `beat_valid` is 1 on the following consecutive cycles for exactly the burst length, and `beat_last` is 1 only on the final beat.
- R3: `req_bl8` = 1 selects an 8-beat burst and `req_bl8` = 0 selects a 4-beat burst.
- R4: Mask polarity is active high (1 = lane not written). On the first beat, `beat_mask[i]` = NOT `req_be[i]` for data lanes i = 0..7.
- R5: Every beat after the first has all nine mask bits set (9'h1FF).
- R6: The ECC lane `beat_mask[8]` is 0 when all eight data lanes of that beat are unmasked, and 1 otherwise.
- R7: With `req_ecc_en` = 1 and `req_be` not equal to 8'hFF, the block drives `rmw_req` high for exactly the cycle after acceptance and emits no beats for that request.
- R8: With `req_ecc_en` = 1 and `req_be` = 8'hFF, the request is a normal burst whose first beat has mask 9'h000.
- R9: `beat_col` on beat n equals (`req_offset` + n) modulo the burst length. For a 4-beat burst, only `req_offset[1:0]` is used and `beat_col[2]` is 0.
- R10: `req_ready` is 0 on every beat of a burst except the last one. A request presented while `req_ready` is 0 is ignored and changes neither the remaining beats nor anything that follows.
- R11: A request accepted in the cycle of a last beat takes effect in the next cycle with no idle cycle: its first beat, or its `rmw_req` pulse, appears then.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Write request present |
| req_offset | input | 3 | Beat column of the target doubleword within the burst |
| req_be | input | 8 | Byte enables of the doubleword, 1 = write the byte |
| req_bl8 | input | 1 | 1 = 8-beat burst, 0 = 4-beat burst |
| req_ecc_en | input | 1 | ECC is enabled for this write |
| req_ready | output | 1 | Request can be accepted this cycle |
| beat_valid | output | 1 | A mask beat is present |
| beat_mask | output | 9 | Lane masks, bits 7..0 data bytes, bit 8 ECC byte; 1 = masked |
| beat_col | output | 3 | Burst column of the present beat |
| beat_last | output | 1 | Present beat is the final one of its burst |
| rmw_req | output | 1 | One-cycle read-modify-write request |

## Verification
Two events can fall in the same cycle: the final beat of one burst, and the acceptance of the next request, whether that is a new burst or a read-modify-write. The bench provokes this by raising `req_valid` exactly in the cycle that shows `beat_last`. It checks that `req_ready` is high there. On the following cycle it checks either the new burst's first-beat mask and start column, or an `rmw_req` pulse with `beat_valid` low. A request raised in a middle beat is also checked: it must leave the remaining beats unchanged and produce nothing afterwards.

// File: rtl/wmask_pkg.sv
package wmask_pkg;

    localparam int unsigned BYTE_LANES = 8;
    localparam int unsigned MAX_BURST  = 8;
    localparam int unsigned COL_BITS   = $clog2(MAX_BURST);

    typedef enum logic {
        BURST_SHORT = 1'b0,
        BURST_LONG  = 1'b1
    } burst_sel_e;

    typedef struct packed {
        logic [COL_BITS-1:0]   offset;
        logic [BYTE_LANES-1:0] be;
        burst_sel_e            bsel;
        logic                  ecc_en;
    } wr_req_t;

    typedef enum logic [1:0] {
        ACT_NONE  = 2'd0,
        ACT_BURST = 2'd1,
        ACT_RMW   = 2'd2
    } req_action_e;

    function automatic logic full_word(input logic [BYTE_LANES-1:0] be);
        return &be;
    endfunction

    function automatic req_action_e classify(input logic take, input wr_req_t r);
        if (!take)
            return ACT_NONE;
        if (r.ecc_en && !full_word(r.be))
            return ACT_RMW;
        return ACT_BURST;
    endfunction

endpackage

// File: rtl/wmask_beat_seq.sv
module wmask_beat_seq
    import wmask_pkg::*;
#(
    parameter int unsigned MAX_BL = MAX_BURST
) (
    input  logic                          clk,
    input  logic                          rst,
    input  logic                          start,
    input  burst_sel_e                    bsel,
    input  logic [$clog2(MAX_BL)-1:0]     offset,
    output logic                          active,
    output logic                          first,
    output logic                          last,
    output logic [$clog2(MAX_BL)-1:0]     col
);
    localparam int unsigned CW = $clog2(MAX_BL);
    localparam logic [CW-1:0] LONG_END  = CW'(MAX_BL - 1);
    localparam logic [CW-1:0] SHORT_END = CW'(MAX_BL / 2 - 1);

    logic [CW-1:0] num_q;
    logic [CW-1:0] col_q;
    burst_sel_e    bsel_q;
    logic          act_q;

    logic [CW-1:0] wrap_now;
    logic [CW-1:0] wrap_new;

    assign wrap_now = (bsel_q == BURST_LONG) ? LONG_END : SHORT_END;
    assign wrap_new = (bsel   == BURST_LONG) ? LONG_END : SHORT_END;

    always_ff @(posedge clk) begin
        if (rst) begin
            act_q  <= 1'b0;
            num_q  <= '0;
            col_q  <= '0;
            bsel_q <= BURST_SHORT;
        end else if (start) begin
            act_q  <= 1'b1;
            num_q  <= '0;
            col_q  <= offset & wrap_new;
            bsel_q <= bsel;
        end else if (act_q) begin
            if (num_q == wrap_now) begin
                act_q <= 1'b0;
            end else begin
                num_q <= num_q + 1'b1;
                col_q <= (col_q + 1'b1) & wrap_now;
            end
        end
    end

    assign active = act_q;
    assign first  = act_q && (num_q == '0);
    assign last   = act_q && (num_q == wrap_now);
    assign col    = col_q;

endmodule

// File: rtl/wmask_lane_gen.sv
module wmask_lane_gen #(
    parameter int unsigned LANES = 8
) (
    input  logic             active,
    input  logic             first,
    input  logic [LANES-1:0] be,
    output logic [LANES:0]   mask
);
    logic [LANES-1:0] data_mask;

    for (genvar i = 0; i < LANES; i++) begin : g_lane
        assign data_mask[i] = !(active && first && be[i]);
    end

    assign mask = {(|data_mask), data_mask};

endmodule

// File: rtl/burst_wmask_gen.sv
module burst_wmask_gen
    import wmask_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  req_valid,
    input  logic [COL_BITS-1:0]   req_offset,
    input  logic [BYTE_LANES-1:0] req_be,
    input  logic                  req_bl8,
    input  logic                  req_ecc_en,
    output logic                  req_ready,
    output logic                  beat_valid,
    output logic [BYTE_LANES:0]   beat_mask,
    output logic [COL_BITS-1:0]   beat_col,
    output logic                  beat_last
    ,output logic                 rmw_req
);
    wr_req_t               req;
    req_action_e           action;
    logic                  take;
    logic                  seq_active;
    logic                  seq_first;
    logic                  seq_last;
    logic [BYTE_LANES-1:0] be_q;
    logic                  rmw_q;

    assign req.offset = req_offset;
    assign req.be     = req_be;
    assign req.bsel   = req_bl8 ? BURST_LONG : BURST_SHORT;
    assign req.ecc_en = req_ecc_en;

    assign req_ready = !seq_active || seq_last;
    assign take      = req_valid && req_ready;
    assign action    = classify(take, req);

    always_ff @(posedge clk) begin
        if (rst) begin
            be_q  <= '0;
            rmw_q <= 1'b0;
        end else begin
            rmw_q <= (action == ACT_RMW);
            if (action == ACT_BURST)
                be_q <= req.be;
        end
    end

    wmask_beat_seq #(.MAX_BL(MAX_BURST)) u_seq (
        .clk    (clk),
        .rst    (rst),
        .start  (action == ACT_BURST),
        .bsel   (req.bsel),
        .offset (req.offset),
        .active (seq_active),
        .first  (seq_first),
        .last   (seq_last),
        .col    (beat_col)
    );

    wmask_lane_gen #(.LANES(BYTE_LANES)) u_lanes (
        .active (seq_active),
        .first  (seq_first),
        .be     (be_q),
        .mask   (beat_mask)
    );

    assign beat_valid = seq_active;
    assign beat_last  = seq_last;
    assign rmw_req    = rmw_q;

endmodule

// File: rtl/wmask_checker.sv
module wmask_checker
    import wmask_pkg::*;
(
    input logic                  clk,
    input logic                  rst,
    input logic                  req_valid,
    input logic [BYTE_LANES-1:0] req_be,
    input logic                  req_ecc_en,
    input logic                  req_ready,
    input logic                  beat_valid,
    input logic [BYTE_LANES:0]   beat_mask,
    input logic [COL_BITS-1:0]   beat_col,
    input logic                  beat_last,
    input logic                  rmw_req
);
    logic partial_ecc;
    assign partial_ecc = req_ecc_en && (req_be != '1);

    AST_BURST_STARTS: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_ready && !partial_ecc) |=> (beat_valid && !rmw_req)); // R2

    AST_RMW_NO_BEAT: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_ready && partial_ecc) |=> (rmw_req && !beat_valid)); // R7

    AST_TRAIL_MASKED: assert property (@(posedge clk) disable iff (rst)
        (beat_valid && $past(beat_valid) && !$past(beat_last)) |-> (beat_mask == '1)); // R5

    AST_ECC_LANE: assert property (@(posedge clk) disable iff (rst)
        beat_valid |-> (beat_mask[BYTE_LANES] == (beat_mask[BYTE_LANES-1:0] != '0))); // R6

    AST_READY_HELD: assert property (@(posedge clk) disable iff (rst)
        (beat_valid && !beat_last) |-> !req_ready); // R10

    AST_COL_STEP: assert property (@(posedge clk) disable iff (rst)
        (beat_valid && $past(beat_valid) && !$past(beat_last))
            |-> (beat_col[1:0] == $past(beat_col[1:0]) + 2'd1)); // R9

    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
        !beat_valid |-> !beat_last); // R2

endmodule

bind burst_wmask_gen wmask_checker u_chk (
    .clk        (clk),
    .rst        (rst),
    .req_valid  (req_valid),
    .req_be     (req_be),
    .req_ecc_en (req_ecc_en),
    .req_ready  (req_ready),
    .beat_valid (beat_valid),
    .beat_mask  (beat_mask),
    .beat_col   (beat_col),
    .beat_last  (beat_last),
    .rmw_req    (rmw_req)
);

// File: tb/tb_burst_wmask_gen.sv
`timescale 1ns/1ps
module tb_burst_wmask_gen;

    logic       clk = 1'b0;
    logic       rst;
    logic       req_valid;
    logic [2:0] req_offset;
    logic [7:0] req_be;
    logic       req_bl8;
    logic       req_ecc_en;
    logic       req_ready;
    logic       beat_valid;
    logic [8:0] beat_mask;
    logic [2:0] beat_col;
    logic       beat_last;
    logic       rmw_req;

    int n_chk  = 0;
    int n_fail = 0;
    int cycles = 0;

    always #4 clk = ~clk;

    burst_wmask_gen dut (
        .clk        (clk),
        .rst        (rst),
        .req_valid  (req_valid),
        .req_offset (req_offset),
        .req_be     (req_be),
        .req_bl8    (req_bl8),
        .req_ecc_en (req_ecc_en),
        .req_ready  (req_ready),
        .beat_valid (beat_valid),
        .beat_mask  (beat_mask),
        .beat_col   (beat_col),
        .beat_last  (beat_last),
        .rmw_req    (rmw_req)
    );

    always @(posedge clk) begin
        cycles++;
        if (cycles > 20000) begin
            n_fail++;
            $display("FAIL watchdog: run did not finish, actual %0d cycles expected < 20000", cycles);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
            $finish;
        end
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic drive(input logic [7:0] be, input logic [2:0] off,
                         input logic bl8, input logic ecc);
        req_valid  = 1'b1;
        req_be     = be;
        req_offset = off;
        req_bl8    = bl8;
        req_ecc_en = ecc;
    endtask

    // drive at a negedge, accepted at the following posedge, return at next negedge
    task automatic issue(input logic [7:0] be, input logic [2:0] off,
                         input logic bl8, input logic ecc);
        @(negedge clk);
        drive(be, off, bl8, ecc);
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    // checks every beat of a burst; optionally presents a follow-up request on the last beat
    task automatic expect_beats(input logic [7:0] be, input logic [2:0] off, input logic bl8,
                                input bit nxt, input logic [7:0] nbe, input logic [2:0] noff,
                                input logic nbl8, input logic necc);
        int bl;
        logic [8:0] em;
        logic [2:0] ec;
        bl = bl8 ? 8 : 4;
        for (int n = 0; n < bl; n++) begin
            em = (n == 0) ? {(be != 8'hFF), ~be} : 9'h1FF;
            ec = 3'((int'(off) + n) % bl);
            chk("R2 beat_valid", beat_valid, 1);
            chk((n == 0) ? "R4/R6 first mask" : "R5 trailing mask", beat_mask, em);
            chk("R9 beat_col", beat_col, ec);
            chk("R3 beat_last", beat_last, (n == bl - 1));
            chk("R10 req_ready", req_ready, (n == bl - 1));
            if (n == bl - 1 && nxt)
                drive(nbe, noff, nbl8, necc);
            @(negedge clk);
            if (n == bl - 1)
                req_valid = 1'b0;
        end
    endtask

    task automatic t_reset;
        chk("R1 req_ready", req_ready, 1);
        chk("R1 beat_valid", beat_valid, 0);
        chk("R1 beat_last", beat_last, 0);
        chk("R1 rmw_req", rmw_req, 0);
    endtask

    task automatic t_full_bl4;
        issue(8'hFF, 3'd0, 1'b0, 1'b0);
        expect_beats(8'hFF, 3'd0, 1'b0, 0, 8'h0, 3'd0, 1'b0, 1'b0);
        chk("R2 no extra beat", beat_valid, 0);
    endtask

    task automatic t_partial_bl8;
        issue(8'h0F, 3'd5, 1'b1, 1'b0);
        expect_beats(8'h0F, 3'd5, 1'b1, 0, 8'h0, 3'd0, 1'b0, 1'b0);
        chk("R3 burst ended after 8", beat_valid, 0);
        chk("R7 no rmw with ECC off", rmw_req, 0);
    endtask

    task automatic t_offset_wrap_bl4;
        issue(8'h01, 3'd7, 1'b0, 1'b0);
        expect_beats(8'h01, 3'd7, 1'b0, 0, 8'h0, 3'd0, 1'b0, 1'b0);
    endtask

    task automatic t_ecc_full;
        issue(8'hFF, 3'd2, 1'b1, 1'b1);
        chk("R8 first mask ECC full", beat_mask, 9'h000);
        chk("R8 no rmw", rmw_req, 0);
        expect_beats(8'hFF, 3'd2, 1'b1, 0, 8'h0, 3'd0, 1'b0, 1'b0);
    endtask

    task automatic t_rmw;
        issue(8'hF0, 3'd1, 1'b1, 1'b1);
        chk("R7 rmw_req pulse", rmw_req, 1);
        chk("R7 no beat", beat_valid, 0);
        @(negedge clk);
        chk("R7 rmw_req single cycle", rmw_req, 0);
        chk("R7 still no beat", beat_valid, 0);
    endtask

    task automatic t_ignore_busy;
        issue(8'hFF, 3'd0, 1'b0, 1'b0);
        chk("R10 ready low on beat 0", req_ready, 0);
        drive(8'h00, 3'd3, 1'b1, 1'b1);
        @(negedge clk);
        req_valid = 1'b0;
        chk("R10 beat1 mask unchanged", beat_mask, 9'h1FF);
        chk("R10 beat1 col unchanged", beat_col, 3'd1);
        chk("R10 no rmw from ignored req", rmw_req, 0);
        @(negedge clk);
        @(negedge clk);
        chk("R10 last beat col", beat_col, 3'd3);
        chk("R10 last beat flag", beat_last, 1);
        @(negedge clk);
        chk("R10 nothing after ignored req", beat_valid, 0);
        chk("R10 no late rmw", rmw_req, 0);
    endtask

    task automatic t_back_to_back;
        issue(8'hFF, 3'd1, 1'b0, 1'b0);
        expect_beats(8'hFF, 3'd1, 1'b0, 1, 8'h3C, 3'd6, 1'b1, 1'b0);
        chk("R11 next burst no gap", beat_valid, 1);
        expect_beats(8'h3C, 3'd6, 1'b1, 1, 8'h7F, 3'd0, 1'b0, 1'b1);
        chk("R11 rmw right after last beat", rmw_req, 1);
        chk("R11 rmw has no beat", beat_valid, 0);
        @(negedge clk);
        chk("R11 rmw ends", rmw_req, 0);
    endtask

    initial begin
        rst = 1'b1;
        req_valid = 1'b0;
        req_be = '0;
        req_offset = '0;
        req_bl8 = 1'b0;
        req_ecc_en = 1'b0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_full_bl4();
        t_partial_bl8();
        t_offset_wrap_bl4();
        t_ecc_full();
        t_rmw();
        t_ignore_busy();
        t_back_to_back();
        repeat (2) @(negedge clk);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
        $finish;
    end

endmodule